// File: doc/BRIEF.md
# Trigger Packet Receive Stripper

This block sits on a 32-bit receive word stream (80 MHz in the target system) that carries trigger-decision packets. Each packet starts with ten protocol header words and then carries eight trigger payload words. The block throws the header away. It queues the payload in a six-entry staging queue and writes each payload word into an external data-buffer memory. The write address is not sequential: it comes from an event number carried in the first payload word, so every event owns an eight-word slot in the buffer.

A packet that ends early is flagged as truncated. Its payload words that are still queued are thrown away and never written. Words of an earlier, complete packet that are still waiting in the queue are kept and written. Words arriving after the eighteenth are ignored until the end-of-packet strobe. When the queue is full, the block pulls its ready output low. The memory side may stall writes through its own ready input. A wrapping counter records each packet whose last payload word has been written.

Top module: `trig_rx_stripper`

## Requirements
- R1: After reset rx_ready is 1, mem_we is 0, pkt_trunc is 0 and pkt_count is 0.
- R2: The accepted words at positions 0 to 9 of a packet (the first ten) are never written to memory.
- R3: The words at positions 10 to 17 are written to memory in arrival order, with their data unchanged.
- R4: The 13-bit write address is {E, k}. E is bits [9:0] of the word at position 10. k is the word's position minus 10, placed in the low three address bits.
- R5: rx_ready is low exactly while six payload words are queued. A word is taken only in a cycle where rx_valid and rx_ready are both high. No word is lost or duplicated.
- R6: mem_we is high whenever at least one payload word is queued. A write completes at a clock edge where mem_we and mem_wr_ready are both high. While mem_wr_ready is low, mem_addr and mem_data hold their values.
- R7: A word taken with rx_eop at a position below 17 ends a truncated packet. pkt_trunc is high in the following cycle. The packet's queued payload words and the ending word itself are never written, and pkt_count does not advance for that packet.
- R8: Words after position 17 are dropped until rx_eop, and they do not raise pkt_trunc.
- R9: The 8-bit pkt_count increments by one, wrapping from 255 to 0, each time a write to slot index 7 completes.
- R10: A truncation drops only the words of the truncated packet. Every queued word of an earlier complete packet is still written.
- R11: rx_eop on any taken word returns the position count to 0, so the next taken word starts a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive word present |
| rx_eop | input | 1 | Receive word is the last of its packet |
| rx_data | input | 32 | Receive word |
| rx_ready | output | 1 | Block can take a word this cycle |
| mem_wr_ready | input | 1 | Memory accepts the offered write this cycle |
| mem_we | output | 1 | Write offered to memory |
| mem_addr | output | 13 | Write address {event number, slot index} |
| mem_data | output | 32 | Write data |
| pkt_trunc | output | 1 | One-cycle flag for a packet that ended early |
| pkt_count | output | 8 | Count of packets fully written |

## Verification
The bench runs a single packet with the memory always ready. This shows the header drop and the event-slot addressing with no queue effects. Two back-to-back packets against a stalled memory fill the queue, which exercises ready backpressure and held write outputs. A slow memory that accepts one write in four, combined with a truncation, separates a flush that removes only the young packet from one that drops older queued words. Truncations in the header and in the payload, over-long packets, and a long random mix of lengths, gaps and memory stalls are compared cycle by cycle against a queue model. A run of over two hundred packets drives the counter through its wrap.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int WORD_W  = 32;
    localparam int HDR_LEN = 10;
    localparam int PAY_LEN = 8;
    localparam int PKT_LEN = HDR_LEN + PAY_LEN;
    localparam int QDEPTH  = 6;
    localparam int EVT_W   = 10;
    localparam int EVT_LSB = 0;
    localparam int CNT_W   = 8;

    localparam int IDX_W  = $clog2(PAY_LEN);
    localparam int ADDR_W = EVT_W + IDX_W;
    localparam int POS_W  = $clog2(PKT_LEN + 1);
    localparam int QPTR_W = $clog2(QDEPTH);
    localparam int QCNT_W = $clog2(QDEPTH + 1);

    typedef enum logic [1:0] {
        SEG_HDR,
        SEG_PAY,
        SEG_SKIP
    } seg_e;

    typedef struct packed {
        logic              tag;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } slot_t;

    function automatic logic [ADDR_W-1:0] slot_addr(
        input logic [EVT_W-1:0] evt,
        input logic [IDX_W-1:0] idx
    );
        return {evt, idx};
    endfunction

    function automatic logic [QPTR_W-1:0] ring_next(input logic [QPTR_W-1:0] ptr);
        return (ptr == QPTR_W'(QDEPTH - 1)) ? '0 : ptr + QPTR_W'(1);
    endfunction

    function automatic logic [QPTR_W-1:0] ring_back(
        input logic [QPTR_W-1:0] ptr,
        input logic [QCNT_W-1:0] n
    );
        int t;
        t = int'(ptr) - int'(n);
        if (t < 0) t = t + QDEPTH;
        return QPTR_W'(t);
    endfunction

endpackage

// File: rtl/trs_framer.sv
module trs_framer
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_eop,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_ready,
    output logic              push,
    output slot_t             push_slot,
    output logic              flush,
    output logic              pkt_done,
    output logic              cur_tag,
    output logic              pkt_trunc
);

    logic [POS_W-1:0] pos_q;
    logic [EVT_W-1:0] evt_q;
    logic             tag_q;
    logic             trunc_q;
    seg_e             seg;
    logic             take;
    logic             short_end;
    logic [IDX_W-1:0] pidx;
    logic [EVT_W-1:0] evt_now;

    always_comb begin
        if (pos_q < POS_W'(HDR_LEN))      seg = SEG_HDR;
        else if (pos_q < POS_W'(PKT_LEN)) seg = SEG_PAY;
        else                              seg = SEG_SKIP;
    end

    assign take      = rx_valid && rx_ready;
    assign short_end = take && rx_eop && (pos_q < POS_W'(PKT_LEN - 1));
    assign pidx      = IDX_W'(pos_q - POS_W'(HDR_LEN));
    assign evt_now   = (pidx == '0) ? rx_data[EVT_LSB +: EVT_W] : evt_q;

    assign push      = take && (seg == SEG_PAY) && !short_end;
    assign flush     = short_end;
    assign pkt_done  = push && (pos_q == POS_W'(PKT_LEN - 1));
    assign cur_tag   = tag_q;
    assign pkt_trunc = trunc_q;

    always_comb begin
        push_slot.tag  = tag_q;
        push_slot.addr = slot_addr(evt_now, pidx);
        push_slot.data = rx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            evt_q   <= '0;
            tag_q   <= 1'b0;
            trunc_q <= 1'b0;
        end else begin
            trunc_q <= short_end;
            if (take) begin
                if (rx_eop)               pos_q <= '0;
                else if (seg != SEG_SKIP) pos_q <= pos_q + POS_W'(1);
            end
            if (push && (pidx == '0)) evt_q <= evt_now;
            if (pkt_done)             tag_q <= ~tag_q;
        end
    end

    // R7, R11: a truncation always leaves the position count at zero
    a_r7_trunc_restarts: assert property (@(posedge clk) disable iff (rst)
        pkt_trunc |-> (pos_q == '0));

    // R8: past the payload nothing reaches the queue
    a_r8_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_SKIP) |-> !push);

endmodule

// File: rtl/trs_slot_fifo.sv
module trs_slot_fifo
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  slot_t             push_slot,
    input  logic              pop,
    input  logic              flush,
    input  logic              pkt_done,
    input  logic              cur_tag,
    output slot_t             head,
    output logic [QCNT_W-1:0] level
);

    slot_t             slot_q [QDEPTH];
    logic [QPTR_W-1:0] wr_q;
    logic [QPTR_W-1:0] rd_q;
    logic [QCNT_W-1:0] level_q;
    logic [QCNT_W-1:0] live_q;
    logic [QCNT_W-1:0] live_after;
    logic              pop_cur;

    assign head       = slot_q[rd_q];
    assign level      = level_q;
    assign pop_cur    = pop && (head.tag == cur_tag);
    assign live_after = live_q - (pop_cur ? QCNT_W'(1) : QCNT_W'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            level_q <= '0;
            live_q  <= '0;
        end else begin
            if (pop) rd_q <= ring_next(rd_q);
            if (flush) begin
                wr_q    <= ring_back(wr_q, live_after);
                level_q <= level_q - QCNT_W'(pop) - live_after;
                live_q  <= '0;
            end else begin
                if (push) wr_q <= ring_next(wr_q);
                level_q <= level_q + QCNT_W'(push) - QCNT_W'(pop);
                live_q  <= pkt_done ? '0 : live_after + QCNT_W'(push);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) slot_q[wr_q] <= push_slot;
    end

    // R5: nothing enters a full queue
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (level_q == QCNT_W'(QDEPTH)) |-> !push);

    // R6: nothing leaves an empty queue
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> (level_q != '0));

    // R7: the truncating word is never stored
    a_r7_flush_no_push: assert property (@(posedge clk) disable iff (rst)
        flush |-> !push);

    // R10: the young packet never owns more slots than are held
    a_r10_live_bound: assert property (@(posedge clk) disable iff (rst)
        live_q <= level_q);

endmodule

// File: rtl/trs_commit.sv
module trs_commit
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              held,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [WORD_W-1:0] head_data,
    input  logic              mem_wr_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              pop,
    output logic [CNT_W-1:0]  pkt_count
);

    logic [CNT_W-1:0] cnt_q;
    logic             closes;

    assign mem_we    = held;
    assign mem_addr  = head_addr;
    assign mem_data  = head_data;
    assign pop       = held && mem_wr_ready;
    assign closes    = pop && (head_addr[IDX_W-1:0] == IDX_W'(PAY_LEN - 1));
    assign pkt_count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (closes) cnt_q <= cnt_q + CNT_W'(1);
    end

    // R9: the counter only ever steps by one
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/trig_rx_stripper.sv
module trig_rx_stripper
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_eop,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              mem_wr_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              pkt_trunc,
    output logic [CNT_W-1:0]  pkt_count
);

    logic              push;
    slot_t             push_slot;
    logic              flush;
    logic              pkt_done;
    logic              cur_tag;
    logic              pop;
    slot_t             head;
    logic [QCNT_W-1:0] level;

    assign rx_ready = (level != QCNT_W'(QDEPTH));

    trs_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_eop    (rx_eop),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .push      (push),
        .push_slot (push_slot),
        .flush     (flush),
        .pkt_done  (pkt_done),
        .cur_tag   (cur_tag),
        .pkt_trunc (pkt_trunc)
    );

    trs_slot_fifo u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_slot (push_slot),
        .pop       (pop),
        .flush     (flush),
        .pkt_done  (pkt_done),
        .cur_tag   (cur_tag),
        .head      (head),
        .level     (level)
    );

    trs_commit u_commit (
        .clk          (clk),
        .rst          (rst),
        .held         (level != '0),
        .head_addr    (head.addr),
        .head_data    (head.data),
        .mem_wr_ready (mem_wr_ready),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_data     (mem_data),
        .pop          (pop),
        .pkt_count    (pkt_count)
    );

    // R6: a stalled write holds address and data unless a truncation removed it
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_wr_ready) |=> (pkt_trunc || (mem_we && $stable(mem_addr) && $stable(mem_data))));

endmodule

// File: tb/trig_rx_stripper_test.sv
module trig_rx_stripper_test;
    import trs_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic              rx_eop = 1'b0;
    logic [31:0]       rx_data = '0;
    logic              mem_wr_ready = 1'b0;
    logic              rx_ready;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_data;
    logic              pkt_trunc;
    logic [CNT_W-1:0]  pkt_count;

    always #2 clk = ~clk;

    trig_rx_stripper uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eop(rx_eop), .rx_data(rx_data),
        .rx_ready(rx_ready), .mem_wr_ready(mem_wr_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .pkt_trunc(pkt_trunc), .pkt_count(pkt_count)
    );

    typedef struct {
        int addr;
        int data;
        int seq;
    } exp_t;

    exp_t        mq[$];
    int          m_pos, m_evt, m_seq, m_cnt;
    bit          m_trunc;
    int          checks, fails;
    int          hdr_writes, skip_writes, sent_complete;
    int          mem_mode, cyc;
    bit [15:0]   lf = 16'hACE1;
    bit          finished;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // behavioural reference: a queue of pending writes, advanced at each edge
    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_pos = 0; m_evt = 0; m_seq = 0; m_cnt = 0; m_trunc = 0;
        end else begin
            bit ready_pre;
            int idx;
            ready_pre = mq.size() < 6;
            if (mq.size() > 0 && mem_wr_ready) begin
                if (mq[0].addr % 8 == 7) m_cnt = (m_cnt + 1) % 256;
                void'(mq.pop_front());
            end
            m_trunc = 0;
            if (rx_valid && ready_pre) begin
                if (rx_eop && m_pos < 17) begin
                    m_trunc = 1;
                    while (mq.size() > 0 && mq[$].seq == m_seq) void'(mq.pop_back());
                end else if (m_pos >= 10 && m_pos <= 17) begin
                    idx = m_pos - 10;
                    if (idx == 0) m_evt = int'(rx_data[9:0]);
                    mq.push_back('{m_evt * 8 + idx, int'(rx_data), m_seq});
                end
                if (rx_eop) begin
                    m_pos = 0;
                    m_seq++;
                end else if (m_pos < 18) begin
                    m_pos++;
                end
            end
        end
    end

    // per-cycle comparison, memory-ready pattern, write log
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(rx_ready == (mq.size() < 6), "R5 ready vs queue fill", longint'(rx_ready), longint'(mq.size() < 6));
            chk(mem_we == (mq.size() > 0), "R6 write strobe", longint'(mem_we), longint'(mq.size() > 0));
            if (mem_we && mq.size() > 0) begin
                chk(int'(mem_addr) == mq[0].addr, "R4 write address", longint'(mem_addr), longint'(mq[0].addr));
                chk(mem_data == 32'(mq[0].data), "R3 write data", longint'(mem_data), longint'(32'(mq[0].data)));
            end
            chk(pkt_trunc == m_trunc, "R7 truncation flag", longint'(pkt_trunc), longint'(m_trunc));
            chk(int'(pkt_count) == m_cnt, "R9 packet count", longint'(pkt_count), longint'(m_cnt));
        end
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (mem_mode)
            0:       mem_wr_ready = 1'b0;
            1:       mem_wr_ready = 1'b1;
            2:       mem_wr_ready = lf[0];
            default: mem_wr_ready = (cyc % 4 == 0);
        endcase
        if (!rst && mem_we && mem_wr_ready) begin
            if (mem_data[31:28] == 4'hA) hdr_writes++;
            if (mem_data[31:28] == 4'hC) skip_writes++;
        end
    end

    task automatic put_word(input logic [31:0] d, input bit e);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = d;
        rx_eop   = e;
        while (!rx_ready) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_eop   = 1'b0;
        end
    endtask

    task automatic send_pkt(input int p, input int len, input int evt, input bit gaps);
        for (int i = 0; i < len; i++) begin
            logic [31:0] d;
            logic [11:0] pp;
            logic [9:0]  ev;
            pp = p[11:0];
            ev = evt[9:0];
            if (i < 10)       d = {4'hA, 4'h0, pp, 4'h0, i[7:0]};
            else if (i == 10) d = {4'hB, pp, 6'h0, ev};
            else if (i < 18)  d = {4'hB, 4'h1, pp, 4'h0, i[7:0]};
            else              d = {4'hC, 4'h0, pp, 4'h0, i[7:0]};
            put_word(d, i == len - 1);
            if (gaps && $urandom_range(0, 3) == 0) idle(1);
        end
        if (len >= 18) sent_complete++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        mem_mode = 1;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(rx_ready == 1'b1, "R1 ready after reset", longint'(rx_ready), 1);
        chk(mem_we == 1'b0, "R1 no write after reset", longint'(mem_we), 0);
        chk(pkt_trunc == 1'b0, "R1 no truncation after reset", longint'(pkt_trunc), 0);
        chk(pkt_count == '0, "R1 count after reset", longint'(pkt_count), 0);
        rst = 1'b0;

        // single packet, memory always ready (R2, R3, R4)
        send_pkt(1, 18, 5, 0);
        idle(20);
        chk(int'(pkt_count) == 1, "R9 one packet written", longint'(pkt_count), 1);

        // back-to-back packets into a stalled memory (R5, R6, R11)
        mem_mode = 0;
        fork
            begin
                send_pkt(2, 18, 33, 0);
                send_pkt(3, 18, 1023, 0);
            end
            begin
                repeat (40) @(negedge clk);
                chk(rx_ready == 1'b0, "R5 ready low with six queued", longint'(rx_ready), 0);
                chk(mem_we == 1'b1, "R6 write held while stalled", longint'(mem_we), 1);
                repeat (10) @(negedge clk);
                mem_mode = 1;
            end
        join
        idle(30);

        // slow memory: earlier complete packet survives a later truncation (R10)
        mem_mode = 3;
        send_pkt(4, 18, 100, 0);
        send_pkt(5, 13, 101, 0);
        idle(60);
        mem_mode = 1;
        idle(10);
        chk(int'(pkt_count) == sent_complete % 256, "R10 earlier packet fully written",
            longint'(pkt_count), longint'(sent_complete % 256));

        // truncation inside the header and single-word packets (R7)
        send_pkt(6, 5, 7, 0);
        send_pkt(7, 1, 8, 0);
        send_pkt(8, 10, 9, 0);
        send_pkt(10, 15, 11, 0);
        idle(20);
        chk(int'(pkt_count) == sent_complete % 256, "R7 truncated packets not counted",
            longint'(pkt_count), longint'(sent_complete % 256));

        // over-long packet (R8)
        send_pkt(9, 22, 300, 0);
        idle(20);
        chk(skip_writes == 0, "R8 trailing words never written", skip_writes, 0);
        chk(int'(pkt_count) == sent_complete % 256, "R8 over-long packet counted once",
            longint'(pkt_count), longint'(sent_complete % 256));

        // random lengths, gaps and memory stalls
        mem_mode = 2;
        for (int k = 0; k < 40; k++) begin
            int r;
            int len;
            r = $urandom_range(0, 9);
            if (r < 6)       len = 18;
            else if (r == 6) len = $urandom_range(1, 17);
            else             len = 18 + $urandom_range(1, 4);
            send_pkt(11 + k, len, $urandom_range(0, 1023), 1);
        end
        mem_mode = 1;
        idle(40);

        // long run through the counter wrap (R9)
        for (int k = 0; k < 230; k++) send_pkt(100 + k, 18, k % 1024, 0);
        idle(30);
        chk(int'(pkt_count) == sent_complete % 256, "R9 count after wrap",
            longint'(pkt_count), longint'(sent_complete % 256));
        chk(hdr_writes == 0, "R2 header words never written", hdr_writes, 0);
        chk(skip_writes == 0, "R8 no trailing words in whole run", skip_writes, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule